// File: doc/BRIEF.md
# Linked-Descriptor Command Sequencer for a Quad-Lane Serial Flash Controller

The sequencer works through a chain of command descriptors that software has placed in system memory, on behalf of a half-duplex serial controller with up to four data lanes. Software first turns descriptor mode on in the configuration register. It then writes the byte address of the first descriptor to the kick register, and that write starts the walk. For every descriptor the engine reads four 32-bit words, one at a time, over a simple request/response memory port. It checks the data buffer alignment and hands one transfer command to the serial shift engine: buffer address, byte count, direction, lane mode and a hold-chip-select flag. It waits for that command to finish and then follows the next pointer. A null next pointer ends the chain. Only then is a single chain-done status bit raised.

A fetch error, or a buffer address that is not 32-byte aligned, aborts the chain without issuing any further command and raises an error status bit. Both status bits are write-one-to-clear and drive one interrupt line through an enable mask. Two read-only registers show the descriptor in progress and its buffer address.

The walker state machine has six states. IDLE leaves to FETCH on an accepted kick. FETCH leaves to WAIT when the memory port grants the word request. WAIT returns to FETCH after each of the first three words, goes to CHECK after the fourth, and goes back to IDLE on a fetch error. CHECK goes to IDLE on a misaligned buffer and to ISSUE otherwise. ISSUE leaves to RUN when the shift engine accepts the command. RUN, on the done pulse, goes to FETCH for a non-null next pointer, or to IDLE while raising chain-done.

Top module: `qdesc_walker`

## Requirements
- R1: After reset, irq_o, mrd_req and cmd_valid are low, and the configuration (0x00), interrupt-enable (0x04) and interrupt-status (0x08) registers read 0.
- R2: A write of a non-zero value to 0x40 starts a walk only when descriptor mode is on and the engine is idle. The walk fetches words at the written address plus 0, 4, 8 and 12, in that order. A zero value, or a kick while a chain is running, is ignored.
- R3: Word 0 is the data buffer address and word 1 is the next-descriptor address. Word 2 is the control word: bit 0 is direction (0 read, 1 write), bits 3:1 are the lane mode, bit 8 is the fragment flag and bits 31:16 are the byte count. Bits 7:4 and 15:9 of word 2, and all of word 3, have no effect.
- R4: A byte-count field of 0 is issued as 65536 bytes on the 17-bit cmd_len. Any other value is issued unchanged.
- R5: cmd_hold_cs equals the descriptor's fragment flag (1 keeps chip select asserted into the next transfer).
- R6: Each descriptor yields exactly one command, in chain order. cmd_valid holds with stable fields until cmd_ready. The next descriptor fetch starts only after cmd_done. A next pointer of 0 ends the chain.
- R7: Status bit 31 (chain done) is set once, in the cycle after the last descriptor's cmd_done, and never earlier in the chain.
- R8: A kick while configuration bit 0 (descriptor mode) is 0 causes no fetch and no command.
- R9: A buffer address whose bits 4:0 are not zero aborts the chain. No command is issued, status bit 0 (error) is set and bit 31 is not.
- R10: A fetch response with mrd_rerr set aborts the chain, sets status bit 0 and issues no command.
- R11: irq_o is high exactly when some status bit is set whose matching bit in the enable register (bits 31 and 0) is also set.
- R12: Status bits clear when written with 1 and are unchanged when written with 0. A status bit set by the engine in the same cycle as a clearing write stays set.
- R13: 0x44 reads the address of the descriptor being processed, and 0x48 reads its buffer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mrd_req | output | 1 | Descriptor word read request |
| mrd_addr | output | 32 | Descriptor word byte address |
| mrd_gnt | input | 1 | Memory port accepts the request |
| mrd_rvalid | input | 1 | Read response valid |
| mrd_rdata | input | 32 | Read response word |
| mrd_rerr | input | 1 | Read response error |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Shift engine accepts the command |
| cmd_addr | output | 32 | Data buffer address |
| cmd_len | output | 17 | Transfer length in bytes (1 to 65536) |
| cmd_dir | output | 1 | 0 read, 1 write |
| cmd_lanes | output | 3 | Lane mode code |
| cmd_hold_cs | output | 1 | Keep chip select asserted after this transfer |
| cmd_done | input | 1 | One-cycle pulse: current command finished |
| irq_o | output | 1 | Interrupt request |

## Verification
The engine raising chain-done and software clearing status can fall in the same clock cycle. The bench leaves the error bit set from an earlier misaligned chain, holds back the final cmd_done, and then drives it in the very cycle it writes 0x8000_0001 to the status register. The result is correct when status reads 0x8000_0000 afterwards: the stale error bit is gone and the fresh done bit has survived the clear.

// File: rtl/qdw_pkg.sv
package qdw_pkg;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int LEN_W = 16;
    localparam int RA_W  = 8;
    localparam int LANE_W = 3;

    localparam logic [RA_W-1:0] OFS_CFG   = 8'h00;
    localparam logic [RA_W-1:0] OFS_IEN   = 8'h04;
    localparam logic [RA_W-1:0] OFS_ISTAT = 8'h08;
    localparam logic [RA_W-1:0] OFS_KICK  = 8'h40;
    localparam logic [RA_W-1:0] OFS_CDESC = 8'h44;
    localparam logic [RA_W-1:0] OFS_CMEM  = 8'h48;

    localparam int BIT_DONE = 31;
    localparam int BIT_ERR  = 0;
    localparam logic [DW-1:0] STAT_MASK = (DW'(1) << BIT_DONE) | (DW'(1) << BIT_ERR);

    localparam int DESC_WORDS = 4;
    localparam int WIDX_W     = $clog2(DESC_WORDS);

    localparam int CF_DIR    = 0;
    localparam int CF_LANE   = 1;
    localparam int CF_FRAG   = 8;
    localparam int CF_LEN    = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_CHECK,
        ST_ISSUE,
        ST_RUN
    } walk_state_t;

    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [LEN_W:0]    len;
        logic              dir;
        logic [LANE_W-1:0] lanes;
        logic              hold_cs;
    } xfer_cmd_t;
endpackage

// File: rtl/qdw_regs.sv
module qdw_regs
    import qdw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            done_set,
    input  logic            err_set,
    input  logic            idle,
    input  logic [AW-1:0]   cur_desc,
    input  logic [AW-1:0]   cur_mem,
    output logic            start,
    output logic [AW-1:0]   start_addr,
    output logic [DW-1:0]   stat_o,
    output logic            irq_o
);
    logic          mode_en_q;
    logic [DW-1:0] ien_q;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] stat_d;
    logic [AW-1:0] kick_q;
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;
    logic          wr_kick;

    assign wr_kick    = reg_we && (reg_addr == OFS_KICK);
    assign start      = wr_kick && mode_en_q && idle && (reg_wdata != '0);
    assign start_addr = {reg_wdata[AW-1:2], 2'b00};

    always_comb begin
        set_vec = '0;
        set_vec[BIT_DONE] = done_set;
        set_vec[BIT_ERR]  = err_set;
        clr_vec = (reg_we && reg_addr == OFS_ISTAT) ? reg_wdata : '0;
        stat_d  = ((stat_q & ~clr_vec) | set_vec) & STAT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_en_q <= 1'b0;
            ien_q     <= '0;
            stat_q    <= '0;
            kick_q    <= '0;
        end else begin
            stat_q <= stat_d;
            if (reg_we && reg_addr == OFS_CFG) mode_en_q <= reg_wdata[0];
            if (reg_we && reg_addr == OFS_IEN) ien_q <= reg_wdata & STAT_MASK;
            if (start) kick_q <= start_addr;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CFG:   reg_rdata = {{(DW-1){1'b0}}, mode_en_q};
            OFS_IEN:   reg_rdata = ien_q;
            OFS_ISTAT: reg_rdata = stat_q;
            OFS_KICK:  reg_rdata = kick_q;
            OFS_CDESC: reg_rdata = cur_desc;
            OFS_CMEM:  reg_rdata = cur_mem;
            default:   reg_rdata = '0;
        endcase
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & ien_q);
endmodule

// File: rtl/qdw_walker.sv
module qdw_walker
    import qdw_pkg::*;
#(
    parameter int ALIGN_LOG2 = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          mrd_req,
    output logic [AW-1:0] mrd_addr,
    input  logic          mrd_gnt,
    input  logic          mrd_rvalid,
    input  logic [DW-1:0] mrd_rdata,
    input  logic          mrd_rerr,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output xfer_cmd_t     cmd,
    input  logic          cmd_done,
    output logic          done_set,
    output logic          err_set,
    output logic          idle,
    output logic [AW-1:0] cur_desc,
    output logic [AW-1:0] cur_mem
);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(DESC_WORDS - 1);

    walk_state_t       state_q, state_d;
    logic [AW-1:0]     desc_q;
    logic [AW-1:0]     mem_q;
    logic [AW-1:0]     next_q;
    logic              dir_q;
    logic [LANE_W-1:0] lanes_q;
    logic              frag_q;
    logic [LEN_W-1:0]  len_q;
    logic [WIDX_W-1:0] widx_q;
    logic              misaligned;
    logic              last_desc;

    assign misaligned = (mem_q[ALIGN_LOG2-1:0] != '0);
    assign last_desc  = (next_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: if (mrd_gnt) state_d = ST_WAIT;
            ST_WAIT: begin
                if (mrd_rvalid) begin
                    if (mrd_rerr)              state_d = ST_IDLE;
                    else if (widx_q == LAST_W) state_d = ST_CHECK;
                    else                       state_d = ST_FETCH;
                end
            end
            ST_CHECK: state_d = misaligned ? ST_IDLE : ST_ISSUE;
            ST_ISSUE: if (cmd_ready) state_d = ST_RUN;
            ST_RUN:   if (cmd_done) state_d = last_desc ? ST_IDLE : ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state and descriptor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            desc_q  <= '0;
            mem_q   <= '0;
            next_q  <= '0;
            dir_q   <= 1'b0;
            lanes_q <= '0;
            frag_q  <= 1'b0;
            len_q   <= '0;
            widx_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                desc_q <= start_addr;
                widx_q <= '0;
            end
            if (state_q == ST_WAIT && mrd_rvalid) begin
                if (mrd_rerr) begin
                    widx_q <= '0;
                end else begin
                    widx_q <= widx_q + 1'b1;
                    unique case (widx_q)
                        2'd0: mem_q  <= mrd_rdata;
                        2'd1: next_q <= mrd_rdata;
                        2'd2: begin
                            dir_q   <= mrd_rdata[CF_DIR];
                            lanes_q <= mrd_rdata[CF_LANE +: LANE_W];
                            frag_q  <= mrd_rdata[CF_FRAG];
                            len_q   <= mrd_rdata[CF_LEN +: LEN_W];
                        end
                        default: ;
                    endcase
                end
            end
            if (state_q == ST_RUN && cmd_done && !last_desc) begin
                desc_q <= next_q;
                widx_q <= '0;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        mrd_req   = 1'b0;
        cmd_valid = 1'b0;
        done_set  = 1'b0;
        err_set   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: mrd_req = 1'b1;
            ST_WAIT:  err_set = mrd_rvalid && mrd_rerr;
            ST_CHECK: err_set = misaligned;
            ST_ISSUE: cmd_valid = 1'b1;
            ST_RUN:   done_set = cmd_done && last_desc;
            default:  ;
        endcase
    end

    assign idle         = (state_q == ST_IDLE);
    assign mrd_addr     = desc_q + (AW'(widx_q) << 2);
    assign cmd.addr     = mem_q;
    assign cmd.len      = (len_q == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_q};
    assign cmd.dir      = dir_q;
    assign cmd.lanes    = lanes_q;
    assign cmd.hold_cs  = frag_q;
    assign cur_desc     = desc_q;
    assign cur_mem      = mem_q;
endmodule

// File: rtl/qdesc_walker.sv
module qdesc_walker
    import qdw_pkg::*;
#(
    parameter int ALIGN_LOG2 = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mrd_req,
    output logic [31:0] mrd_addr,
    input  logic        mrd_gnt,
    input  logic        mrd_rvalid,
    input  logic [31:0] mrd_rdata,
    input  logic        mrd_rerr,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [31:0] cmd_addr,
    output logic [16:0] cmd_len,
    output logic        cmd_dir,
    output logic [2:0]  cmd_lanes,
    output logic        cmd_hold_cs,
    input  logic        cmd_done,
    output logic        irq_o
);
    logic          start;
    logic [AW-1:0] start_addr;
    logic          done_set;
    logic          err_set;
    logic          idle;
    logic [AW-1:0] cur_desc;
    logic [AW-1:0] cur_mem;
    logic [DW-1:0] stat_vis;
    xfer_cmd_t     cmd;

    qdw_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .done_set   (done_set),
        .err_set    (err_set),
        .idle       (idle),
        .cur_desc   (cur_desc),
        .cur_mem    (cur_mem),
        .start      (start),
        .start_addr (start_addr),
        .stat_o     (stat_vis),
        .irq_o      (irq_o)
    );

    qdw_walker #(.ALIGN_LOG2(ALIGN_LOG2)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .mrd_req    (mrd_req),
        .mrd_addr   (mrd_addr),
        .mrd_gnt    (mrd_gnt),
        .mrd_rvalid (mrd_rvalid),
        .mrd_rdata  (mrd_rdata),
        .mrd_rerr   (mrd_rerr),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd        (cmd),
        .cmd_done   (cmd_done),
        .done_set   (done_set),
        .err_set    (err_set),
        .idle       (idle),
        .cur_desc   (cur_desc),
        .cur_mem    (cur_mem)
    );

    assign cmd_addr    = cmd.addr;
    assign cmd_len     = cmd.len;
    assign cmd_dir     = cmd.dir;
    assign cmd_lanes   = cmd.lanes;
    assign cmd_hold_cs = cmd.hold_cs;
endmodule

// File: rtl/qdw_chk.sv
module qdw_chk #(
    parameter int ALIGN_LOG2 = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mrd_req,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [31:0] cmd_addr,
    input logic        cmd_done,
    input logic        stat_done
);
    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr));

    // R6
    fetch_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mrd_req && cmd_valid));

    // R7
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_done) |-> $past(cmd_done));

    // R9
    cmd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_addr[ALIGN_LOG2-1:0] == '0);
endmodule

bind qdesc_walker qdw_chk #(.ALIGN_LOG2(ALIGN_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrd_req   (mrd_req),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_done  (cmd_done),
    .stat_done (stat_vis[31])
);

// File: tb/qdesc_walker_tb_top.sv
module qdesc_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_gnt;
    logic        mrd_rvalid = 1'b0;
    logic [31:0] mrd_rdata = 32'h0;
    logic        mrd_rerr = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_addr;
    logic [16:0] cmd_len;
    logic        cmd_dir;
    logic [2:0]  cmd_lanes;
    logic        cmd_hold_cs;
    logic        cmd_done;
    logic        irq_o;

    logic        auto_en = 1'b1;
    logic        auto_done = 1'b0;
    logic        man_done = 1'b0;
    int          dcnt = 0;

    logic [31:0] mem [0:255];
    int          req_cnt = 0;
    logic [31:0] req_log [0:63];
    int          cap_n = 0;
    logic [31:0] cap_addr [0:15];
    logic [16:0] cap_len [0:15];
    logic        cap_dir [0:15];
    logic [2:0]  cap_lanes [0:15];
    logic        cap_hold [0:15];

    int n_chk = 0;
    int n_bad = 0;
    logic run_done = 1'b0;

    localparam logic [31:0] ERR_BASE = 32'h0000_0380;

    localparam logic [31:0] TV_ADDR [4] = '{32'h0000_2000, 32'h1234_5660, 32'hFFFF_FFE0, 32'h0000_0020};
    localparam logic [31:0] TV_CTRL [4] = '{32'h0040_0000, 32'h0100_0105, 32'h0000_00FF, 32'hFFFF_0106};
    localparam logic [16:0] TV_LEN  [4] = '{17'd64, 17'd256, 17'h10000, 17'd65535};
    localparam logic        TV_DIR  [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [2:0]  TV_LANE [4] = '{3'd0, 3'd2, 3'd7, 3'd3};
    localparam logic        TV_HOLD [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

    always #4 clk = ~clk;

    assign mrd_gnt   = 1'b1;
    assign cmd_ready = 1'b1;
    assign cmd_done  = auto_done | man_done;

    qdesc_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
        .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata), .mrd_rerr(mrd_rerr),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_dir(cmd_dir), .cmd_lanes(cmd_lanes), .cmd_hold_cs(cmd_hold_cs),
        .cmd_done(cmd_done), .irq_o(irq_o)
    );

    // memory model: one-cycle response
    always @(posedge clk) begin
        mrd_rvalid <= 1'b0;
        mrd_rerr   <= 1'b0;
        if (rst_n && mrd_req && mrd_gnt) begin
            mrd_rvalid <= 1'b1;
            mrd_rdata  <= mem[mrd_addr[9:2]];
            mrd_rerr   <= (mrd_addr >= ERR_BASE);
            req_log[req_cnt % 64] <= mrd_addr;
            req_cnt <= req_cnt + 1;
        end
    end

    // shift engine model
    always @(posedge clk) begin
        auto_done <= 1'b0;
        if (dcnt != 0) begin
            dcnt <= dcnt - 1;
            if (dcnt == 1 && auto_en) auto_done <= 1'b1;
        end
        if (rst_n && cmd_valid && cmd_ready) begin
            cap_addr[cap_n % 16]  <= cmd_addr;
            cap_len[cap_n % 16]   <= cmd_len;
            cap_dir[cap_n % 16]   <= cmd_dir;
            cap_lanes[cap_n % 16] <= cmd_lanes;
            cap_hold[cap_n % 16]  <= cmd_hold_cs;
            cap_n <= cap_n + 1;
            dcnt  <= 3;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        mem[at[9:2]]        = w0;
        mem[at[9:2] + 8'd1] = w1;
        mem[at[9:2] + 8'd2] = w2;
        mem[at[9:2] + 8'd3] = w3;
    endtask

    task automatic wait_caps(input int n);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cap_n >= n) break;
        end
    endtask

    task automatic pulse_done();
        @(negedge clk); man_done = 1'b1;
        @(negedge clk); man_done = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!run_done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int base;
        int rbase;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;

        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 irq_o", {31'h0, irq_o}, 32'h0);
        check("R1 mrd_req", {31'h0, mrd_req}, 32'h0);
        check("R1 cmd_valid", {31'h0, cmd_valid}, 32'h0);
        reg_read(8'h00, rd); check("R1 cfg", rd, 32'h0);
        reg_read(8'h04, rd); check("R1 ien", rd, 32'h0);
        reg_read(8'h08, rd); check("R1 stat", rd, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        reg_write(8'h00, 32'h1);

        // table of single-descriptor chains: R3 R4 R5 R7
        for (int v = 0; v < 4; v++) begin
            base  = cap_n;
            rbase = req_cnt;
            put_desc(32'h100, TV_ADDR[v], 32'h0, TV_CTRL[v], 32'hDEAD_BEEF);
            reg_write(8'h40, 32'h100);
            wait_caps(base + 1);
            repeat (8) @(negedge clk);
            check("R6 one cmd", cap_n - base, 1);
            check("R3 addr", cap_addr[base % 16], TV_ADDR[v]);
            check("R4 len", {15'h0, cap_len[base % 16]}, {15'h0, TV_LEN[v]});
            check("R3 dir", {31'h0, cap_dir[base % 16]}, {31'h0, TV_DIR[v]});
            check("R3 lanes", {29'h0, cap_lanes[base % 16]}, {29'h0, TV_LANE[v]});
            check("R5 hold", {31'h0, cap_hold[base % 16]}, {31'h0, TV_HOLD[v]});
            if (v == 0) begin
                check("R2 fetch count", req_cnt - rbase, 4);
                for (int k = 0; k < 4; k++)
                    check("R2 fetch addr", req_log[(rbase + k) % 64], 32'h100 + 32'(4 * k));
            end
            reg_read(8'h08, rd); check("R7 done set", rd, 32'h8000_0000);
            reg_write(8'h08, 32'h8000_0000);
            reg_read(8'h08, rd); check("R12 done cleared", rd, 32'h0);
        end

        // three-descriptor chain under manual done: R6 R7 R13 R2
        auto_en = 1'b0;
        put_desc(32'h200, 32'h1000, 32'h240, 32'h0010_0100, 32'h0);
        put_desc(32'h240, 32'h2000, 32'h280, 32'h0010_0100, 32'h0);
        put_desc(32'h280, 32'h3000, 32'h0,   32'h0010_0000, 32'h0);
        base = cap_n;
        reg_write(8'h40, 32'h200);
        wait_caps(base + 1);
        reg_read(8'h44, rd); check("R13 cur desc", rd, 32'h200);
        reg_read(8'h48, rd); check("R13 cur mem", rd, 32'h1000);
        reg_read(8'h08, rd); check("R7 not early", rd, 32'h0);
        reg_write(8'h40, 32'h100);  // busy kick, ignored
        repeat (10) @(negedge clk);
        check("R6 waits for done", cap_n - base, 1);
        pulse_done();
        wait_caps(base + 2);
        reg_read(8'h44, rd); check("R13 cur desc 2", rd, 32'h240);
        reg_read(8'h08, rd); check("R7 not early 2", rd, 32'h0);
        pulse_done();
        wait_caps(base + 3);
        pulse_done();
        repeat (10) @(negedge clk);
        check("R2 busy kick ignored", cap_n - base, 3);
        check("R6 order 0", cap_addr[base % 16], 32'h1000);
        check("R6 order 1", cap_addr[(base + 1) % 16], 32'h2000);
        check("R6 order 2", cap_addr[(base + 2) % 16], 32'h3000);
        check("R5 hold chain", {29'h0, cap_hold[base % 16], cap_hold[(base + 1) % 16], cap_hold[(base + 2) % 16]}, 32'h6);
        reg_read(8'h08, rd); check("R7 done at end", rd, 32'h8000_0000);
        reg_write(8'h08, 32'h8000_0000);
        auto_en = 1'b1;

        // R8 disabled mode
        reg_write(8'h00, 32'h0);
        base = cap_n; rbase = req_cnt;
        reg_write(8'h40, 32'h100);
        repeat (20) @(negedge clk);
        check("R8 no fetch", req_cnt - rbase, 0);
        check("R8 no cmd", cap_n - base, 0);
        reg_write(8'h00, 32'h1);

        // R2 zero kick
        rbase = req_cnt;
        reg_write(8'h40, 32'h0);
        repeat (20) @(negedge clk);
        check("R2 zero kick", req_cnt - rbase, 0);

        // R9 misaligned buffer
        put_desc(32'h140, 32'h0000_1008, 32'h0, 32'h0010_0000, 32'h0);
        base = cap_n;
        reg_write(8'h40, 32'h140);
        repeat (30) @(negedge clk);
        check("R9 no cmd", cap_n - base, 0);
        reg_read(8'h08, rd); check("R9 err only", rd, 32'h1);
        reg_write(8'h08, 32'h0);
        reg_read(8'h08, rd); check("R12 write 0 keeps", rd, 32'h1);

        // R12 set and clear in the same cycle
        auto_en = 1'b0;
        put_desc(32'h100, 32'h0000_2000, 32'h0, 32'h0040_0000, 32'h0);
        base = cap_n;
        reg_write(8'h40, 32'h100);
        wait_caps(base + 1);
        @(negedge clk);
        man_done = 1'b1; reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h8000_0001;
        @(negedge clk);
        man_done = 1'b0; reg_we = 1'b0;
        reg_read(8'h08, rd); check("R12 set beats clear", rd, 32'h8000_0000);
        reg_write(8'h08, 32'h8000_0000);
        auto_en = 1'b1;

        // R10 fetch error
        base = cap_n;
        reg_write(8'h40, ERR_BASE);
        repeat (20) @(negedge clk);
        check("R10 no cmd", cap_n - base, 0);
        reg_read(8'h08, rd); check("R10 err", rd, 32'h1);

        // R11 interrupt masking
        @(negedge clk); check("R11 masked", {31'h0, irq_o}, 32'h0);
        reg_write(8'h04, 32'h1);
        @(negedge clk); check("R11 enabled", {31'h0, irq_o}, 32'h1);
        reg_write(8'h04, 32'h8000_0000);
        @(negedge clk); check("R11 other bit", {31'h0, irq_o}, 32'h0);
        reg_write(8'h04, 32'h8000_0001);
        reg_write(8'h08, 32'h1);
        @(negedge clk); check("R11 cleared", {31'h0, irq_o}, 32'h0);

        run_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule